// File: doc/BRIEF.md
# Graphics-Port Request Scheduler

This block takes transfer requests for a graphics-port bus into four request queues and hands them, one at a time, to a downstream transfer engine. The four queues hold high-priority reads, high-priority writes, low-priority graphics requests (reads and writes mixed), and PCI-type requests. Each queue has its own valid/ready enqueue port that carries a tag, an address and a write flag.

The scheduler picks the next request only when no transfer is in flight. High-priority work always wins over low-priority work at that point, but a transfer that has already been handed out is never interrupted. Within a priority level, the two competing queues take turns. The graphics queue and the PCI queue each keep their own arrival order. The downstream engine accepts an offered request with `iss_ready` and later reports the end of the transfer with `xfer_done`. Only then does the scheduler choose again.

Top module: `gport_req_sched`

## Requirements
- R1: When a choice is made and any high-priority queue holds a request, a high-priority request is offered. The class codes on `iss_cls` are 0 for high-priority read, 1 for high-priority write, 2 for low-priority graphics and 3 for PCI.
- R2: Once a request has been accepted (`iss_valid` and `iss_ready` high at a clock edge), no request is offered until `xfer_done` has been seen. A high-priority request that arrives meanwhile waits.
- R3: A choice is made only in a cycle with no offer and no transfer in flight, using the queue contents of that cycle. A request accepted into an empty, idle scheduler is offered from the second clock edge after its enqueue.
- R4: When both high-priority queues hold requests, the choice alternates between them. Serving either queue makes the other one preferred next.
- R5: When no high-priority request is pending and both low-priority queues hold requests, the choice alternates between graphics and PCI in the same way.
- R6: PCI-type requests are offered in the order they were enqueued.
- R7: Low-priority graphics reads and writes share one queue and are offered in enqueue order.
- R8: Each queue holds 4 requests. Its ready output is low while it is full. A request held on a full queue's port is taken once space frees and is never lost.
- R9: An offer stays valid, with tag, address, write flag and class unchanged, until `iss_ready` accepts it.
- R10: `xfer_done` has no effect while no accepted transfer is in flight.
- R11: Synchronous active-high reset empties all queues, withdraws any offer and forgets any transfer in flight. All ready outputs are high after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hpr_valid | input | 1 | High-priority read enqueue valid |
| hpr_ready | output | 1 | High-priority read queue has space |
| hpr_tag | input | TAG_W | High-priority read tag |
| hpr_addr | input | ADDR_W | High-priority read address |
| hpr_wr | input | 1 | High-priority read write flag |
| hpw_valid | input | 1 | High-priority write enqueue valid |
| hpw_ready | output | 1 | High-priority write queue has space |
| hpw_tag | input | TAG_W | High-priority write tag |
| hpw_addr | input | ADDR_W | High-priority write address |
| hpw_wr | input | 1 | High-priority write write flag |
| lpa_valid | input | 1 | Low-priority graphics enqueue valid |
| lpa_ready | output | 1 | Low-priority graphics queue has space |
| lpa_tag | input | TAG_W | Low-priority graphics tag |
| lpa_addr | input | ADDR_W | Low-priority graphics address |
| lpa_wr | input | 1 | Low-priority graphics write flag |
| pci_valid | input | 1 | PCI-type enqueue valid |
| pci_ready | output | 1 | PCI-type queue has space |
| pci_tag | input | TAG_W | PCI-type tag |
| pci_addr | input | ADDR_W | PCI-type address |
| pci_wr | input | 1 | PCI-type write flag |
| iss_valid | output | 1 | Request offered to the transfer engine |
| iss_ready | input | 1 | Transfer engine accepts the offer |
| iss_cls | output | 2 | Class of the offered request |
| iss_tag | output | TAG_W | Tag of the offered request |
| iss_addr | output | ADDR_W | Address of the offered request |
| iss_wr | output | 1 | Write flag of the offered request |
| xfer_done | input | 1 | Accepted transfer has finished |

## Verification
The hardest case to reach is a high-priority request that arrives while a low-priority transfer is running and then meets competition at the next boundary. Another hard case is a queue that becomes full at the same moment its head is taken. To reach both, the stimulus runs phases with long, randomly delayed transfers while all four queues are driven hard. Each sender holds its request on a full queue until it is taken, and the engine pulses `xfer_done` at random outside transfers. A behavioural queue model in the bench predicts every ready, offer and payload cycle by cycle, and a reset in the middle of a busy phase checks recovery.

// File: rtl/gport_req_sched.sv
module gport_req_sched #(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hpr_valid,
  output logic              hpr_ready,
  input  logic [TAG_W-1:0]  hpr_tag,
  input  logic [ADDR_W-1:0] hpr_addr,
  input  logic              hpr_wr,
  input  logic              hpw_valid,
  output logic              hpw_ready,
  input  logic [TAG_W-1:0]  hpw_tag,
  input  logic [ADDR_W-1:0] hpw_addr,
  input  logic              hpw_wr,
  input  logic              lpa_valid,
  output logic              lpa_ready,
  input  logic [TAG_W-1:0]  lpa_tag,
  input  logic [ADDR_W-1:0] lpa_addr,
  input  logic              lpa_wr,
  input  logic              pci_valid,
  output logic              pci_ready,
  input  logic [TAG_W-1:0]  pci_tag,
  input  logic [ADDR_W-1:0] pci_addr,
  input  logic              pci_wr,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [1:0]        iss_cls,
  output logic [TAG_W-1:0]  iss_tag,
  output logic [ADDR_W-1:0] iss_addr,
  output logic              iss_wr,
  input  logic              xfer_done
);
  localparam int NQ    = 4;
  localparam int ENT_W = TAG_W + ADDR_W + 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_OFFER, S_RUN} st_t;

  st_t              st;
  logic             pref_hw, pref_pci;
  logic [1:0]       grant;
  logic             take;
  logic [NQ-1:0]    in_v, in_rdy, pop, nonempty;
  logic [ENT_W-1:0] in_d [NQ];
  logic [ENT_W-1:0] head [NQ];

  assign in_v  = {pci_valid, lpa_valid, hpw_valid, hpr_valid};
  assign in_d[0] = {hpr_wr, hpr_tag, hpr_addr};
  assign in_d[1] = {hpw_wr, hpw_tag, hpw_addr};
  assign in_d[2] = {lpa_wr, lpa_tag, lpa_addr};
  assign in_d[3] = {pci_wr, pci_tag, pci_addr};
  assign {pci_ready, lpa_ready, hpw_ready, hpr_ready} = in_rdy;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd, wr;
    logic [CNT_W-1:0] cnt;
    logic             push;

    assign push        = in_v[q] && in_rdy[q];
    assign in_rdy[q]   = cnt < CNT_W'(DEPTH);
    assign nonempty[q] = cnt != '0;
    assign head[q]     = mem[rd];
    assign pop[q]      = take && (grant == 2'(q));

    always_ff @(posedge clk) begin
      if (rst) begin
        rd  <= '0;
        wr  <= '0;
        cnt <= '0;
      end else begin
        if (push) wr <= (wr == PTR_W'(DEPTH - 1)) ? '0 : wr + 1'b1;
        if (pop[q]) rd <= (rd == PTR_W'(DEPTH - 1)) ? '0 : rd + 1'b1;
        if (push && !pop[q]) cnt <= cnt + 1'b1;
        else if (!push && pop[q]) cnt <= cnt - 1'b1;
      end
    end

    always_ff @(posedge clk)
      if (!rst && push) mem[wr] <= in_d[q];
  end

  always_comb begin
    if (nonempty[0] && nonempty[1]) grant = pref_hw ? 2'd1 : 2'd0;
    else if (nonempty[0])           grant = 2'd0;
    else if (nonempty[1])           grant = 2'd1;
    else if (nonempty[2] && nonempty[3]) grant = pref_pci ? 2'd3 : 2'd2;
    else if (nonempty[3])           grant = 2'd3;
    else                            grant = 2'd2;
  end

  assign take      = (st == S_IDLE) && (|nonempty);
  assign iss_valid = (st == S_OFFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      pref_hw  <= 1'b0;
      pref_pci <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st <= S_OFFER;
          if (!grant[1]) pref_hw  <= ~grant[0];
          else           pref_pci <= ~grant[0];
        end
        S_OFFER: if (iss_ready) st <= S_RUN;
        S_RUN:   if (xfer_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (take) begin
      iss_cls <= grant;
      {iss_wr, iss_tag, iss_addr} <= head[grant];
    end
endmodule

module gport_req_sched_chk #(
  parameter int DEPTH = 4,
  parameter int PAY_W = 37
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       q_valid,
  input logic [3:0]       q_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [1:0]       iss_cls,
  input logic [PAY_W-1:0] iss_pay,
  input logic             xfer_done
);
  localparam int CW = $clog2(DEPTH + 2) + 1;

  logic [CW-1:0] occ [4];
  logic          prev_v, busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_v <= 1'b0;
      busy   <= 1'b0;
      for (int q = 0; q < 4; q++) occ[q] <= '0;
    end else begin
      prev_v <= iss_valid;
      if (iss_valid && iss_ready) busy <= 1'b1;
      else if (busy && xfer_done) busy <= 1'b0;
      for (int q = 0; q < 4; q++)
        occ[q] <= occ[q] + CW'(q_valid[q] && q_ready[q])
                         - CW'(iss_valid && !prev_v && iss_cls == 2'(q));
    end
  end

  assert_offer_hold_R9: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_pay) && $stable(iss_cls));

  assert_no_preempt_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !iss_valid);

  assert_boundary_gap_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !iss_valid);

  assert_high_first_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(iss_valid) && iss_cls[1] |-> $past(occ[0]) == '0 && $past(occ[1]) == '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    occ[0] <= CW'(DEPTH) && occ[1] <= CW'(DEPTH) && occ[2] <= CW'(DEPTH) && occ[3] <= CW'(DEPTH));
endmodule

bind gport_req_sched gport_req_sched_chk #(.DEPTH(DEPTH), .PAY_W(TAG_W + ADDR_W + 1)) chk_i (
  .clk(clk), .rst(rst),
  .q_valid({pci_valid, lpa_valid, hpw_valid, hpr_valid}),
  .q_ready({pci_ready, lpa_ready, hpw_ready, hpr_ready}),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cls(iss_cls),
  .iss_pay({iss_wr, iss_tag, iss_addr}), .xfer_done(xfer_done)
);

// File: tb/gport_req_sched_tb_top.sv
module gport_req_sched_tb_top;
  localparam int TAG_W = 4, ADDR_W = 32, DEPTH = 4;
  localparam int ENT_W = TAG_W + ADDR_W + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] v = '0;
  logic [TAG_W-1:0] tg [4];
  logic [ADDR_W-1:0] ad [4];
  logic wrf [4];
  logic iss_ready = 1'b0, xfer_done = 1'b0;
  logic [3:0] rdy;
  logic iss_valid, iss_wr;
  logic [1:0] iss_cls;
  logic [TAG_W-1:0] iss_tag;
  logic [ADDR_W-1:0] iss_addr;

  always #4 clk = ~clk;

  gport_req_sched #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .hpr_valid(v[0]), .hpr_ready(rdy[0]), .hpr_tag(tg[0]), .hpr_addr(ad[0]), .hpr_wr(wrf[0]),
    .hpw_valid(v[1]), .hpw_ready(rdy[1]), .hpw_tag(tg[1]), .hpw_addr(ad[1]), .hpw_wr(wrf[1]),
    .lpa_valid(v[2]), .lpa_ready(rdy[2]), .lpa_tag(tg[2]), .lpa_addr(ad[2]), .lpa_wr(wrf[2]),
    .pci_valid(v[3]), .pci_ready(rdy[3]), .pci_tag(tg[3]), .pci_addr(ad[3]), .pci_wr(wrf[3]),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cls(iss_cls), .iss_tag(iss_tag),
    .iss_addr(iss_addr), .iss_wr(iss_wr), .xfer_done(xfer_done)
  );

  int n_chk = 0, n_fail = 0;
  int p_hp, p_lp, p_rdy, dly_max, p_spur, dly;
  logic [ENT_W-1:0] mq [4][$];
  int mstate = 0;
  logic [1:0] mcls;
  logic [ENT_W-1:0] ment;
  bit pref_hw = 0, pref_pci = 0;
  bit acc [4];
  logic [TAG_W-1:0] seq [4];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: spec-level queues and a three-phase engine handshake
  always @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < 4; q++) begin mq[q].delete(); acc[q] = 0; end
      mstate = 0; pref_hw = 0; pref_pci = 0;
    end else begin
      int sz [4];
      for (int q = 0; q < 4; q++) begin
        sz[q] = mq[q].size();
        acc[q] = v[q] && sz[q] < DEPTH;
      end
      case (mstate)
        0: if (sz[0] + sz[1] + sz[2] + sz[3] > 0) begin
          int g;
          if (sz[0] > 0 && sz[1] > 0) g = pref_hw ? 1 : 0;
          else if (sz[0] > 0 || sz[1] > 0) g = sz[0] > 0 ? 0 : 1;
          else if (sz[2] > 0 && sz[3] > 0) g = pref_pci ? 3 : 2;
          else g = sz[3] > 0 ? 3 : 2;
          if (g < 2) pref_hw = (g == 0); else pref_pci = (g == 2);
          ment = mq[g].pop_front();
          mcls = 2'(g);
          mstate = 1;
        end
        1: if (iss_ready) begin mstate = 2; dly = $urandom % (dly_max + 1); end
        default: if (xfer_done) mstate = 0;
      endcase
      for (int q = 0; q < 4; q++)
        if (acc[q]) mq[q].push_back({wrf[q], tg[q], ad[q]});
    end
  end

  task automatic compare();
    for (int q = 0; q < 4; q++)
      chk(rdy[q] == (mq[q].size() < DEPTH), rst ? "R11" : "R8", $sformatf("ready q%0d", q),
          longint'(rdy[q]), longint'(mq[q].size() < DEPTH));
    chk(iss_valid == (mstate == 1),
        mstate == 2 ? "R2" : (mstate == 1 ? "R9 R10" : "R3 R10"), "iss_valid",
        longint'(iss_valid), longint'(mstate == 1));
    if (mstate == 1 && iss_valid) begin
      chk(iss_cls == mcls, (iss_cls[1] != mcls[1]) ? "R1" : (mcls[1] ? "R5" : "R4"),
          "iss_cls", longint'(iss_cls), longint'(mcls));
      chk({iss_wr, iss_tag, iss_addr} == ment,
          mcls == 3 ? "R6" : (mcls == 2 ? "R7" : "R9"), "payload",
          longint'({iss_wr, iss_tag, iss_addr}), longint'(ment));
    end
  endtask

  task automatic drive();
    for (int q = 0; q < 4; q++)
      if (acc[q] || !v[q]) begin
        v[q] = ($urandom % 100) < (q < 2 ? p_hp : p_lp);
        seq[q] = seq[q] + 1'b1;
        tg[q] = seq[q];
        ad[q] = $urandom;
        wrf[q] = (q == 0) ? 1'b0 : (q == 1) ? 1'b1 : 1'($urandom % 2);
      end
    iss_ready = ($urandom % 100) < p_rdy;
    if (mstate == 2) begin
      if (dly == 0) xfer_done = 1'b1;
      else begin dly--; xfer_done = 1'b0; end
    end else xfer_done = ($urandom % 100) < p_spur;
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare();
      drive();
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    for (int q = 0; q < 4; q++) begin seq[q] = '0; tg[q] = '0; ad[q] = '0; wrf[q] = 1'b0; end
    dly = 0;
    p_hp = 0; p_lp = 0; p_rdy = 100; dly_max = 0; p_spur = 0;
    repeat (3) @(negedge clk);
    chk(iss_valid == 1'b0, "R11", "iss_valid in reset", longint'(iss_valid), 0);
    chk(rdy == 4'hF, "R11", "ready in reset", longint'(rdy), 4'hF);
    rst = 1'b0;
    // mixed traffic, short transfers, stray done pulses
    p_hp = 30; p_lp = 30; p_rdy = 70; dly_max = 3; p_spur = 10;
    run(2000);
    // low-priority flood, long transfers: queues fill and back-pressure
    p_hp = 0; p_lp = 90; p_rdy = 60; dly_max = 12; p_spur = 20;
    run(1500);
    // high-priority arrivals during long low-priority transfers
    p_hp = 60; p_lp = 60; p_rdy = 50; dly_max = 15; p_spur = 30;
    run(1500);
    // reset while busy
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(iss_valid == 1'b0, "R11", "iss_valid after reset", longint'(iss_valid), 0);
    chk(rdy == 4'hF, "R11", "ready after reset", longint'(rdy), 4'hF);
    rst = 1'b0;
    // high-priority only, slow acceptance, many stray done pulses
    p_hp = 80; p_lp = 0; p_rdy = 30; dly_max = 6; p_spur = 50;
    run(1500);
    // drain
    p_hp = 0; p_lp = 0; p_rdy = 100; dly_max = 2; p_spur = 0;
    run(300);
    chk(iss_valid == 1'b0 && rdy == 4'hF, "R3", "drained idle",
        longint'({iss_valid, rdy}), longint'(5'h0F));
    finish_up();
  end
endmodule